// File: doc/BRIEF.md
# Byte-Command I2C Bus Controller

This block is a standard-mode I2C controller that software or a sequencer drives one bus step at a time. Each command does one step: a START (also used as a repeated START), a STOP, a data byte write, an address phase, or a data byte read. An address phase takes an unshifted 7-bit target address and appends the direction bit. When the step is done, the controller sets a result flag and keeps it set until the user clears it. The acknowledge outcome and the received byte stay readable for that whole time.

The controller attaches to an open-drain bus. It reads back the real SCL and SDA levels, and it only requests that a line be pulled low; it never drives a line high. A SCL half-period lasts `HALF_TICKS` clock cycles. The default of 500 gives 100 kHz SCL from a 100 MHz clock. A high phase counts only while SCL is actually observed high, so a target that holds SCL low simply stretches the clock.

Top module: `i2cByteMaster`

## Requirements
- R1: While reset is asserted and after it is released, busy, cmdRefused and resultValid are 0 and both pull-low outputs are 0, so the bus is released.
- R2: Command code 0 (START) releases SDA, releases SCL, then pulls SDA low while SCL is high, and one half-period later pulls SCL low. SDA and SCL stay pulled low afterwards, and ackSeen and nackSeen are 0.
- R3: In byte commands (codes 2 to 5), eight bits go out MSB first and then a ninth bit. SDA changes only while SCL has been pulled low for at least one cycle.
- R4: After a write byte (code 2) or an address phase (codes 3 and 4), the ninth bit is sampled in the middle of the ninth SCL high phase. SDA low there sets ackSeen to 1; SDA high sets nackSeen to 1. The two flags are never 1 together.
- R5: Address commands send {cmdArg[6:0], rw}. Code 3 sets rw to 0 (write) and code 4 sets rw to 1 (read).
- R6: For an address command with cmdArg above 0x7F, cmdRefused is 1 for the next cycle. busy stays 0, both pull-low outputs keep their values, and the result outputs do not change.
- R7: Read byte (code 5) releases SDA for eight bits and captures them MSB first into readData. On the ninth clock it pulls SDA low when cmdAckSel is 1 and releases it when cmdAckSel is 0. ackSeen and nackSeen are 0 after a read.
- R8: Command code 1 (STOP) pulls SDA low under a low SCL, releases SCL, and releases SDA one half-period later. Both lines end up released.
- R9: resultValid goes to 1 when a command completes. It stays 1, and readData, ackSeen and nackSeen stay constant, until resultClear is asserted or another command is accepted.
- R10: busy is 1 from the cycle after a command is accepted until it completes. A command presented while busy is 1 is ignored.
- R11: Timing counted in clock cycles from the acceptance edge: resultValid rises 3*HALF_TICKS+1 cycles later for START or STOP and 18*HALF_TICKS+2 cycles later for a byte command. When a target holds SCL low past the controller's own low phase, completion is delayed by exactly the extra hold time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | Command strobe; accepted when busy is 0 |
| cmdOp | input | 3 | 0 START, 1 STOP, 2 write byte, 3 write address, 4 read address, 5 read byte; 6 and 7 are ignored |
| cmdArg | input | 8 | Data byte for code 2, unshifted address for codes 3 and 4 |
| cmdAckSel | input | 1 | For code 5: 1 sends ACK, 0 sends NACK |
| resultClear | input | 1 | Clears resultValid |
| busy | output | 1 | A command is executing |
| cmdRefused | output | 1 | One-cycle pulse for a rejected address |
| resultValid | output | 1 | Sticky completion flag |
| ackSeen | output | 1 | Target acknowledged the last written byte |
| nackSeen | output | 1 | Target did not acknowledge the last written byte |
| readData | output | 8 | Byte captured by the last read |
| sclIn | input | 1 | Observed SCL level |
| sdaIn | input | 1 | Observed SDA level |
| sclPullLow | output | 1 | Request to pull SCL low |
| sdaPullLow | output | 1 | Request to pull SDA low |

## Verification
The assertions check four things on every cycle. SDA moves only under a low SCL during byte commands. The acknowledge flags are never set together. The result stays frozen while it is valid and not cleared. Accepted commands raise busy, and refused addresses leave the bus untouched. Other properties show up only in the bench's scenarios against a modelled target on a wired-AND bus. Those are the START and STOP line orderings as the bus decodes them, MSB-first bit order with the direction bit, the captured read byte and the master's own ACK or NACK, the exact completion latencies, the extra delay from clock stretching, and the dropping of a command issued mid-transfer.

// File: rtl/i2cmPkg.sv
package i2cmPkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int FRAME_BITS = BYTE_W + 1;

  typedef enum logic [2:0] {
    OP_START   = 3'd0,
    OP_STOP    = 3'd1,
    OP_WRITE   = 3'd2,
    OP_WR_ADDR = 3'd3,
    OP_RD_ADDR = 3'd4,
    OP_READ    = 3'd5
  } cmdOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic load;       // latch a new command, clear result
    logic tickRun;    // advance the half-period counter
    logic shift;      // move to next frame bit
    logic sample;     // capture SDA
    logic resultSet;  // publish result
  } ctrlStrobesT;
endpackage

// File: rtl/i2cmDatapath.sv
module i2cmDatapath
  import i2cmPkg::*;
#(
  parameter int HALF_TICKS = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic [2:0]        cmdOp,
  input  logic [BYTE_W-1:0] cmdArg,
  input  logic              cmdAckSel,
  input  logic              resultClear,
  input  logic              sdaIn,
  output logic              halfDone,
  output logic              midHigh,
  output logic              txBit,
  output logic              lastBit,
  output logic              resultValid,
  output logic              ackSeen,
  output logic              nackSeen,
  output logic [BYTE_W-1:0] readData
);
  localparam int CW = $clog2(HALF_TICKS + 1);
  localparam int BCW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(HALF_TICKS - 1);
  localparam logic [CW-1:0] MID_TICK = CW'(HALF_TICKS / 2);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME_BITS - 1);

  logic [CW-1:0] tickCnt;
  logic [BCW-1:0] bitCnt;
  logic [FRAME_BITS-1:0] txWord, rxWord, loadWord;
  logic isByteOp, isReadOp;

  assign halfDone = strobes.tickRun && (tickCnt == LAST_TICK);
  assign midHigh = strobes.tickRun && (tickCnt == MID_TICK);
  assign txBit = txWord[FRAME_BITS-1];
  assign lastBit = (bitCnt == LAST_BIT);

  always_comb begin
    case (cmdOp)
      OP_WRITE:   loadWord = {cmdArg, 1'b1};
      OP_WR_ADDR: loadWord = {cmdArg[ADDR_W-1:0], 1'b0, 1'b1};
      OP_RD_ADDR: loadWord = {cmdArg[ADDR_W-1:0], 1'b1, 1'b1};
      OP_READ:    loadWord = {{BYTE_W{1'b1}}, ~cmdAckSel};
      default:    loadWord = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (strobes.load) begin
      tickCnt <= '0;
    end else if (strobes.tickRun) begin
      tickCnt <= halfDone ? '0 : tickCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txWord <= '1;
      rxWord <= '0;
      bitCnt <= '0;
      isByteOp <= 1'b0;
      isReadOp <= 1'b0;
    end else begin
      if (strobes.load) begin
        txWord <= loadWord;
        bitCnt <= '0;
        isByteOp <= (cmdOp >= OP_WRITE);
        isReadOp <= (cmdOp == OP_READ);
      end else if (strobes.shift) begin
        txWord <= {txWord[FRAME_BITS-2:0], 1'b1};
        bitCnt <= bitCnt + 1'b1;
      end
      if (strobes.sample) begin
        rxWord <= {rxWord[FRAME_BITS-2:0], sdaIn};
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultValid <= 1'b0;
      ackSeen <= 1'b0;
      nackSeen <= 1'b0;
      readData <= '0;
    end else if (strobes.load) begin
      resultValid <= 1'b0;
      ackSeen <= 1'b0;
      nackSeen <= 1'b0;
    end else if (strobes.resultSet) begin
      resultValid <= 1'b1;
      ackSeen <= isByteOp && !isReadOp && !rxWord[0];
      nackSeen <= isByteOp && !isReadOp && rxWord[0];
      readData <= isReadOp ? rxWord[FRAME_BITS-1:1] : '0;
    end else if (resultClear) begin
      resultValid <= 1'b0;
    end
  end
endmodule

// File: rtl/i2cmControl.sv
module i2cmControl
  import i2cmPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [BYTE_W-1:0] cmdArg,
  input  logic              sclIn,
  input  logic              halfDone,
  input  logic              midHigh,
  input  logic              txBit,
  input  logic              lastBit,
  output ctrlStrobesT       strobes,
  output logic              busy,
  output logic              cmdRefused,
  output logic              sclPullLow,
  output logic              sdaPullLow
);
  typedef enum logic [3:0] {
    S_IDLE, S_ST_REL, S_ST_HIGH, S_ST_LOW,
    S_SP_LOW, S_SP_HIGH, S_SP_REL,
    S_BIT_LOW, S_BIT_HIGH, S_BYTE_END, S_FINISH
  } stateE;

  stateE state;
  logic isAddrOp, badAddr, knownOp, accept;

  assign isAddrOp = (cmdOp == OP_WR_ADDR) || (cmdOp == OP_RD_ADDR);
  assign badAddr = isAddrOp && cmdArg[BYTE_W-1];
  assign knownOp = (cmdOp <= OP_READ);
  assign accept = (state == S_IDLE) && cmdValid && knownOp && !badAddr;
  assign busy = (state != S_IDLE);

  always_comb begin
    strobes = '0;
    strobes.load = accept;
    case (state)
      S_ST_REL, S_ST_LOW, S_SP_LOW, S_SP_REL, S_BIT_LOW: strobes.tickRun = 1'b1;
      S_ST_HIGH, S_SP_HIGH, S_BIT_HIGH:                  strobes.tickRun = sclIn;
      default:                                           strobes.tickRun = 1'b0;
    endcase
    strobes.shift = (state == S_BIT_HIGH) && halfDone && !lastBit;
    strobes.sample = (state == S_BIT_HIGH) && midHigh;
    strobes.resultSet = (state == S_FINISH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      sclPullLow <= 1'b0;
      sdaPullLow <= 1'b0;
      cmdRefused <= 1'b0;
    end else begin
      cmdRefused <= (state == S_IDLE) && cmdValid && badAddr;
      case (state)
        S_IDLE: begin
          if (accept) begin
            case (cmdOp)
              OP_START: begin sdaPullLow <= 1'b0; state <= S_ST_REL; end
              OP_STOP:  begin sclPullLow <= 1'b1; state <= S_SP_LOW; end
              default:  begin sclPullLow <= 1'b1; state <= S_BIT_LOW; end
            endcase
          end
        end
        S_ST_REL:  if (halfDone) begin sclPullLow <= 1'b0; state <= S_ST_HIGH; end
        S_ST_HIGH: if (halfDone) begin sdaPullLow <= 1'b1; state <= S_ST_LOW; end
        S_ST_LOW:  if (halfDone) begin sclPullLow <= 1'b1; state <= S_FINISH; end
        S_SP_LOW: begin
          sdaPullLow <= 1'b1;
          if (halfDone) begin sclPullLow <= 1'b0; state <= S_SP_HIGH; end
        end
        S_SP_HIGH: if (halfDone) begin sdaPullLow <= 1'b0; state <= S_SP_REL; end
        S_SP_REL:  if (halfDone) state <= S_FINISH;
        S_BIT_LOW: begin
          sdaPullLow <= ~txBit;
          if (halfDone) begin sclPullLow <= 1'b0; state <= S_BIT_HIGH; end
        end
        S_BIT_HIGH: begin
          if (halfDone) begin
            sclPullLow <= 1'b1;
            state <= lastBit ? S_BYTE_END : S_BIT_LOW;
          end
        end
        S_BYTE_END: begin sdaPullLow <= 1'b0; state <= S_FINISH; end
        S_FINISH:   state <= S_IDLE;
        default:    state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2cByteMaster.sv
module i2cByteMaster
  import i2cmPkg::*;
#(
  parameter int HALF_TICKS = 500
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [BYTE_W-1:0] cmdArg,
  input  logic              cmdAckSel,
  input  logic              resultClear,
  output logic              busy,
  output logic              cmdRefused,
  output logic              resultValid,
  output logic              ackSeen,
  output logic              nackSeen,
  output logic [BYTE_W-1:0] readData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sclPullLow,
  output logic              sdaPullLow
);
  ctrlStrobesT strobes;
  logic halfDone, midHigh, txBit, lastBit;

  i2cmControl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .sclIn(sclIn), .halfDone(halfDone), .midHigh(midHigh), .txBit(txBit),
    .lastBit(lastBit), .strobes(strobes), .busy(busy), .cmdRefused(cmdRefused),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
  );

  i2cmDatapath #(.HALF_TICKS(HALF_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .cmdAckSel(cmdAckSel), .resultClear(resultClear), .sdaIn(sdaIn),
    .halfDone(halfDone), .midHigh(midHigh), .txBit(txBit), .lastBit(lastBit),
    .resultValid(resultValid), .ackSeen(ackSeen), .nackSeen(nackSeen),
    .readData(readData)
  );
endmodule

// File: rtl/i2cmChecker.sv
module i2cmChecker (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic [2:0] cmdOp,
  input logic [7:0] cmdArg,
  input logic       resultClear,
  input logic       busy,
  input logic       cmdRefused,
  input logic       resultValid,
  input logic       ackSeen,
  input logic       nackSeen,
  input logic [7:0] readData,
  input logic       sclPullLow,
  input logic       sdaPullLow
);
  logic [2:0] curOp;
  logic offered, addrBad, goodCmd, byteOp;

  assign offered = cmdValid && !busy;
  assign addrBad = ((cmdOp == 3'd3) || (cmdOp == 3'd4)) && cmdArg[7];
  assign goodCmd = offered && (cmdOp <= 3'd5) && !addrBad;
  assign byteOp = busy && (curOp >= 3'd2) && (curOp <= 3'd5);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curOp <= 3'd0;
    else if (goodCmd) curOp <= cmdOp;
  end

  // R3
  sda_under_low_scl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteOp && !$stable(sdaPullLow)) |-> (sclPullLow && $past(sclPullLow)));

  // R4
  ack_nack_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(ackSeen && nackSeen));

  // R6
  refused_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (offered && addrBad) |=> (cmdRefused && !busy && $stable(sclPullLow) && $stable(sdaPullLow)));

  // R9
  result_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultValid && !resultClear && !offered) |=>
      (resultValid && $stable(readData) && $stable(ackSeen) && $stable(nackSeen)));

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    goodCmd |=> busy);
endmodule

bind i2cByteMaster i2cmChecker u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
  .resultClear(resultClear), .busy(busy), .cmdRefused(cmdRefused),
  .resultValid(resultValid), .ackSeen(ackSeen), .nackSeen(nackSeen),
  .readData(readData), .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
);

// File: tb/i2cByteMaster_test.sv
module i2cByteMaster_test;
  localparam int H = 16;
  localparam int STRETCH = 40;
  localparam int LAT_BYTE = 18 * H + 2;
  localparam int LAT_CTL = 3 * H + 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdAckSel = 1'b0, resultClear = 1'b0;
  logic [2:0] cmdOp = 3'd0;
  logic [7:0] cmdArg = 8'd0;
  logic busy, cmdRefused, resultValid, ackSeen, nackSeen, sclPullLow, sdaPullLow;
  logic [7:0] readData;
  logic sclIn, sdaIn;
  logic tgtSclHold = 1'b0, tgtSdaLow = 1'b0;

  // target-side stimulus, written only by the main sequence
  logic tgtMode = 1'b0, tgtAck = 1'b1, stretchArm = 1'b0;
  logic [7:0] tgtByte = 8'd0;
  int armCnt = 0;

  // scoreboard: kind 1 START, 2 STOP, 3 byte {ninth, data}
  logic [10:0] expQ[$];
  string tagQ[$];
  int rdIdx = 0;
  int drvChecks = 0, drvFails = 0, monChecks = 0, monFails = 0;
  logic finished = 1'b0;

  assign sclIn = !sclPullLow && !tgtSclHold;
  assign sdaIn = !sdaPullLow && !tgtSdaLow;

  always #2 clk = ~clk;

  i2cByteMaster #(.HALF_TICKS(H)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdArg(cmdArg),
    .cmdAckSel(cmdAckSel), .resultClear(resultClear), .busy(busy),
    .cmdRefused(cmdRefused), .resultValid(resultValid), .ackSeen(ackSeen),
    .nackSeen(nackSeen), .readData(readData), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclPullLow(sclPullLow), .sdaPullLow(sdaPullLow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    drvChecks++;
    if (act !== exp) begin
      drvFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic expectEv(input logic [1:0] kind, input logic ninth, input logic [7:0] data,
                          input string req);
    expQ.push_back({kind, ninth, data});
    tagQ.push_back(req);
  endtask

  // monitor: bus decoder plus target model, sole writer of its state
  logic lastScl = 1'b1, lastSda = 1'b1, armed = 1'b0;
  int seenArm = 0, bitIdx = 0;
  logic [7:0] obs = 8'd0;

  task automatic gotEv(input logic [10:0] ev);
    monChecks++;
    if (rdIdx >= expQ.size()) begin
      monFails++;
      $display("FAIL bus event: actual %0h expected none", ev);
    end else begin
      if (ev !== expQ[rdIdx]) begin
        monFails++;
        $display("FAIL %s bus event: actual %0h expected %0h", tagQ[rdIdx], ev, expQ[rdIdx]);
      end
      rdIdx++;
    end
  endtask

  always @(sclIn or sdaIn or armCnt) begin
    if (rstN) begin
      if (armCnt != seenArm) begin
        seenArm = armCnt;
        armed = 1'b1;
        bitIdx = 0;
        tgtSdaLow = tgtMode && !tgtByte[7];
      end
      if (sclIn && lastScl && !sdaIn && lastSda) gotEv({2'd1, 9'd0});
      else if (sclIn && lastScl && sdaIn && !lastSda) gotEv({2'd2, 9'd0});
      if (sclIn && !lastScl && armed) begin
        if (bitIdx < 8) obs = {obs[6:0], sdaIn};
        else begin
          gotEv({2'd3, sdaIn, obs});
          armed = 1'b0;
        end
        bitIdx++;
      end
      if (!sclIn && lastScl) begin
        if (!armed) tgtSdaLow = 1'b0;
        else if (tgtMode) tgtSdaLow = (bitIdx < 8) ? !tgtByte[7-bitIdx] : 1'b0;
        else tgtSdaLow = (bitIdx == 8) && tgtAck;
      end
    end
    lastScl = sclIn;
    lastSda = sdaIn;
  end

  // clock stretch: hold SCL low from the next fall for STRETCH cycles
  initial forever begin
    wait (stretchArm);
    @(negedge sclIn);
    tgtSclHold = 1'b1;
    repeat (STRETCH) @(posedge clk);
    @(negedge clk);
    tgtSclHold = 1'b0;
    wait (!stretchArm);
  end

  task automatic runCmd(input logic [2:0] op, input logic [7:0] arg, input logic ackSel,
                        input bit inject, output int lat);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdArg = arg; cmdAckSel = ackSel;
    @(negedge clk);
    cmdValid = 1'b0;
    lat = 0;
    while (!resultValid && lat < 5000) begin
      @(negedge clk);
      lat++;
      if (inject && lat == 30) begin cmdValid = 1'b1; cmdOp = 3'd0; end
      if (inject && lat == 31) cmdValid = 1'b0;
    end
  endtask

  task automatic armTarget(input logic mode, input logic ack, input logic [7:0] b);
    tgtMode = mode; tgtAck = ack; tgtByte = b;
    armCnt++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures",
               drvChecks + monChecks + 1, drvFails + monFails + 1);
      $finish;
    end
  end

  initial begin
    int lat;
    logic sclKeep, sdaKeep;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 pulls in reset", {sclPullLow, sdaPullLow}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {busy, cmdRefused, resultValid, sclPullLow, sdaPullLow}, 0);

    // R2 START from idle bus
    expectEv(2'd1, 1'b0, 8'd0, "R2");
    runCmd(3'd0, 8'd0, 1'b0, 1'b0, lat);
    chk("R11 start latency", lat, LAT_CTL);
    chk("R2 start lines held low", {sclPullLow, sdaPullLow}, 2'b11);
    chk("R2 start ack flags", {ackSeen, nackSeen}, 0);

    // R5 write address 0x5A, target ACKs
    armTarget(1'b0, 1'b1, 8'd0);
    expectEv(2'd3, 1'b0, 8'hB4, "R5");
    runCmd(3'd3, 8'h5A, 1'b0, 1'b0, lat);
    chk("R11 byte latency", lat, LAT_BYTE);
    chk("R4 ack on address", {ackSeen, nackSeen}, 2'b10);
    chk("R10 busy low after completion", busy, 0);

    // R3 R4 data byte, target NACKs
    armTarget(1'b0, 1'b0, 8'd0);
    expectEv(2'd3, 1'b1, 8'h3C, "R3");
    runCmd(3'd2, 8'h3C, 1'b0, 1'b0, lat);
    chk("R4 nack on data", {ackSeen, nackSeen}, 2'b01);

    // R9 sticky result
    repeat (50) @(negedge clk);
    chk("R9 result still valid", {resultValid, nackSeen}, 2'b11);
    resultClear = 1'b1;
    @(negedge clk);
    resultClear = 1'b0;
    chk("R9 cleared", resultValid, 0);

    // R6 refused address
    sclKeep = sclPullLow; sdaKeep = sdaPullLow;
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = 3'd4; cmdArg = 8'h80;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R6 refused pulse", {cmdRefused, busy}, 2'b10);
    repeat (20) @(negedge clk);
    chk("R6 no bus activity", {busy, resultValid, sclPullLow, sdaPullLow}, {2'b00, sclKeep, sdaKeep});

    // R2 repeated START, then R5 read address 0x7F
    expectEv(2'd1, 1'b0, 8'd0, "R2");
    runCmd(3'd0, 8'd0, 1'b0, 1'b0, lat);
    chk("R2 repeated start latency", lat, LAT_CTL);
    armTarget(1'b0, 1'b1, 8'd0);
    expectEv(2'd3, 1'b0, 8'hFF, "R5");
    runCmd(3'd4, 8'h7F, 1'b0, 1'b0, lat);
    chk("R5 read address acked", ackSeen, 1);

    // R7 read with ACK then with NACK
    armTarget(1'b1, 1'b0, 8'hA5);
    expectEv(2'd3, 1'b0, 8'hA5, "R7");
    runCmd(3'd5, 8'd0, 1'b1, 1'b0, lat);
    chk("R7 read data A5", readData, 8'hA5);
    chk("R7 flags after read", {ackSeen, nackSeen}, 0);
    chk("R11 read latency", lat, LAT_BYTE);
    armTarget(1'b1, 1'b0, 8'h3E);
    expectEv(2'd3, 1'b1, 8'h3E, "R7");
    runCmd(3'd5, 8'd0, 1'b0, 1'b0, lat);
    chk("R7 read data 3E", readData, 8'h3E);

    // R10 command while busy is dropped
    armTarget(1'b0, 1'b1, 8'd0);
    expectEv(2'd3, 1'b0, 8'h81, "R10");
    runCmd(3'd2, 8'h81, 1'b0, 1'b1, lat);
    chk("R10 latency unaffected", lat, LAT_BYTE);
    repeat (5) @(negedge clk);
    chk("R10 no second command", {busy, ackSeen}, 2'b01);

    // R11 clock stretching
    armTarget(1'b0, 1'b1, 8'd0);
    stretchArm = 1'b1;
    expectEv(2'd3, 1'b0, 8'h6D, "R11");
    runCmd(3'd2, 8'h6D, 1'b0, 1'b0, lat);
    stretchArm = 1'b0;
    chk("R11 stretched latency", lat, LAT_BYTE + STRETCH - H);

    // R8 STOP
    expectEv(2'd2, 1'b0, 8'd0, "R8");
    runCmd(3'd1, 8'd0, 1'b0, 1'b0, lat);
    chk("R8 stop latency", lat, LAT_CTL);
    chk("R8 bus released", {sclPullLow, sdaPullLow, sclIn, sdaIn}, 4'b0011);

    repeat (10) @(negedge clk);
    chk("R3 all bus events seen", rdIdx, expQ.size());
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures",
             drvChecks + monChecks, drvFails + monFails);
    $finish;
  end
endmodule